// File: doc/BRIEF.md
# Descriptor-Chained Memory Copy Engine

This block copies data from one memory region to another under the control of descriptor chains that live in that same memory. It has a transmit channel and a receive channel. The transmit channel walks its chain, reads each source buffer and feeds the words into a small internal FIFO. The receive channel walks its own chain and stores the words from that FIFO into its destination buffers. Both channels share one request/grant memory port. Memory accepts a request in the cycle in which `mem_gnt` is high. Read data comes back one cycle later with `mem_rvalid`.

Software builds both chains in memory. It then pulses the receive start with the address of the first receive descriptor, and after that pulses the transmit start. When a frame is complete, the engine returns each consumed descriptor to the CPU. It records in the receive descriptor how many bytes arrived and whether the frame ended there, and it raises a completion interrupt. An optional ownership check stops a channel and flags an error when a descriptor is not marked as owned by the engine. An optional write-back step hands each descriptor back by clearing its owner bit.

Top module: `desc_copy_dma`

## Requirements
- R1: During and after reset, `mem_req`, both busy outputs, both error flags and `rx_eof_irq` are low.
- R2: A descriptor is three 32-bit words at consecutive byte addresses D, D+4 and D+8. The first word holds the control fields: bit 31 is the owner bit (1 = engine, 0 = CPU), bit 30 is end-of-frame, bits 23:12 are the valid length in bytes and bits 11:0 are the buffer size in bytes. The word at D+4 is the buffer address and the word at D+8 is the next-descriptor address. A next address of zero ends the chain. Lengths and sizes are non-zero multiples of 4.
- R3: The words reach the destination in the same order as in the source. They are written to ascending addresses, and each source word appears exactly once.
- R4: When `owner_chk_en` is high and a fetched descriptor has owner bit 0, that channel moves no data, drops busy and holds its error flag until its next start pulse. When `owner_chk_en` is low, the owner bit is ignored.
- R5: When `auto_wb_en` is high, every consumed transmit and receive descriptor is written back with owner bit 0. When it is low, the owner bit in memory is left unchanged.
- R6: A receive descriptor accepts data up to its size field. When it is full and the frame has not ended, it is written back with length equal to its size and end-of-frame 0, and reception continues with the next receive descriptor.
- R7: When the last word of a transmit descriptor that carries end-of-frame has been stored, the receive descriptor is written back with the actual byte count and end-of-frame 1. `rx_eof_irq` then rises and stays high until the next receive start.
- R8: A memory request that is not granted keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| owner_chk_en | input | 1 | Refuse descriptors not owned by the engine |
| auto_wb_en | input | 1 | Return descriptors to the CPU after use |
| tx_start | input | 1 | Start pulse for the transmit channel |
| tx_desc_addr | input | ADDR_W | First transmit descriptor address |
| rx_start | input | 1 | Start pulse for the receive channel |
| rx_desc_addr | input | ADDR_W | First receive descriptor address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid, one cycle after grant |
| mem_rdata | input | 32 | Read data |
| tx_busy | output | 1 | Transmit channel active |
| rx_busy | output | 1 | Receive channel active |
| tx_err | output | 1 | Transmit ownership failure |
| rx_err | output | 1 | Receive ownership failure |
| rx_eof_irq | output | 1 | Frame received |

## Verification
The copy is tried with several chain shapes. Two transmit descriptors feeding one receive descriptor show that transmit chaining keeps the data in order. One transmit descriptor feeding two receive descriptors shows the split at the size boundary and the intermediate write-back with end-of-frame clear. A short frame in a large buffer shows that the recorded length is the actual byte count and that no words are stored past it. Ownership checking is tried with a bad descriptor on each side and also with checking disabled, and write-back is tried both enabled and disabled. A random memory grant pattern runs throughout, so that stalled requests and the arbitration between the two channels are exercised.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
    localparam int WORD_W = 32;
    localparam int FLD_W  = 12;
    localparam int BPW    = WORD_W / 8;

    // control word of a descriptor
    typedef struct packed {
        logic             owner;   // 1 = engine
        logic             eof;
        logic [5:0]       rsvd;
        logic [FLD_W-1:0] length;
        logic [FLD_W-1:0] size;
    } ctl_t;

    typedef struct packed {
        logic              last;
        logic [WORD_W-1:0] data;
    } beat_t;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_BUF, S_NXT, S_XFER, S_MOVE, S_WB, S_ERR
    } ch_st_e;

    function automatic ctl_t retire(ctl_t d, logic clr, logic eof,
                                    logic [FLD_W-1:0] len);
        ctl_t r = d;
        if (clr) r.owner = 1'b0;
        r.eof    = eof;
        r.length = len;
        return r;
    endfunction
endpackage

// File: rtl/dcp_fifo.sv
module dcp_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         i_valid,
    output logic         i_ready,
    input  logic [W-1:0] i_data,
    output logic         o_valid,
    input  logic         o_ready,
    output logic [W-1:0] o_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;
    logic          push, pop;

    assign i_ready = cnt != (PW+1)'(DEPTH);
    assign o_valid = cnt != '0;
    assign o_data  = store[rp];
    assign push    = i_valid && i_ready;
    assign pop     = o_valid && o_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0; rp <= '0; cnt <= '0;
        end else begin
            if (push) begin
                store[wp] <= i_data;
                wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
            end
            if (pop) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
        end
    end
endmodule

// File: rtl/dcp_arb.sv
module dcp_arb #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    // port a: high priority (receive)
    input  logic              a_req,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [31:0]       a_wdata,
    output logic              a_gnt,
    output logic              a_rvalid,
    // port b: transmit
    input  logic              b_req,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [31:0]       b_wdata,
    output logic              b_gnt,
    output logic              b_rvalid,
    // memory
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid
);
    logic hold_q, sel_q, rd_a_q, sel;

    // a stalled request keeps its slot
    assign sel       = hold_q ? sel_q : a_req;
    assign mem_req   = sel ? a_req   : b_req;
    assign mem_we    = sel ? a_we    : b_we;
    assign mem_addr  = sel ? a_addr  : b_addr;
    assign mem_wdata = sel ? a_wdata : b_wdata;
    assign a_gnt     = sel  && mem_gnt;
    assign b_gnt     = !sel && mem_gnt;
    assign a_rvalid  = mem_rvalid && rd_a_q;
    assign b_rvalid  = mem_rvalid && !rd_a_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0; sel_q <= 1'b0; rd_a_q <= 1'b0;
        end else begin
            hold_q <= mem_req && !mem_gnt;
            sel_q  <= sel;
            if (mem_req && mem_gnt && !mem_we) rd_a_q <= sel;
        end
    end
endmodule

// File: rtl/dcp_chan.sv
module dcp_chan
    import dcp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter bit IS_RX  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              chk_en,
    input  logic              wb_en,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [31:0]       wdata,
    input  logic              gnt,
    input  logic              rvalid,
    input  logic [31:0]       rdata,
    // stream: output for transmit, input for receive
    output logic              s_valid_o,
    output beat_t             s_beat_o,
    input  logic              s_ready_i,
    input  logic              s_valid_i,
    input  beat_t             s_beat_i,
    output logic              s_ready_o,
    output logic              busy,
    output logic              err,
    output logic              eof_irq
);
    ch_st_e            st;
    logic              pend, last_q;
    logic [ADDR_W-1:0] ptr, bufa, nxt;
    ctl_t              hdr;
    logic [FLD_W-1:0]  cnt;
    logic [FLD_W:0]    cnt_nx;
    logic [31:0]       word;
    logic              limit;

    assign cnt_nx = {1'b0, cnt} + (FLD_W+1)'(BPW);
    assign limit  = IS_RX ? (cnt_nx >= {1'b0, hdr.size})
                          : (cnt_nx >= {1'b0, hdr.length});
    assign busy   = (st != S_IDLE) && (st != S_ERR);

    always_comb begin
        req = 1'b0; we = 1'b0; addr = ptr; wdata = hdr;
        s_valid_o = 1'b0; s_ready_o = 1'b0;
        s_beat_o  = '{last: hdr.eof && limit, data: word};
        unique case (st)
            S_HDR: req = !pend;
            S_BUF: begin req = !pend; addr = ptr + ADDR_W'(4); end
            S_NXT: begin req = !pend; addr = ptr + ADDR_W'(8); end
            S_XFER: begin
                addr = bufa + ADDR_W'(cnt);
                if (IS_RX) begin
                    req = s_valid_i; we = 1'b1; wdata = s_beat_i.data;
                    s_ready_o = gnt;
                end else begin
                    req = !pend;
                end
            end
            S_MOVE: s_valid_o = !IS_RX;
            S_WB: begin
                req = IS_RX || wb_en; we = 1'b1;
                wdata = IS_RX ? retire(hdr, wb_en, last_q, cnt)
                              : retire(hdr, 1'b1, hdr.eof, hdr.length);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; pend <= 1'b0; err <= 1'b0; eof_irq <= 1'b0;
            last_q <= 1'b0; ptr <= '0; bufa <= '0; nxt <= '0;
            hdr <= '0; cnt <= '0; word <= '0;
        end else begin
            if (req && gnt && !we) pend <= 1'b1;
            if (rvalid) pend <= 1'b0;
            unique case (st)
                S_IDLE, S_ERR: if (start) begin
                    ptr <= start_addr; err <= 1'b0; eof_irq <= 1'b0;
                    last_q <= 1'b0; st <= S_HDR;
                end
                S_HDR: if (rvalid) begin
                    hdr <= ctl_t'(rdata);
                    if (chk_en && !rdata[31]) begin
                        err <= 1'b1; st <= S_ERR;
                    end else st <= S_BUF;
                end
                S_BUF: if (rvalid) begin bufa <= rdata[ADDR_W-1:0]; st <= S_NXT; end
                S_NXT: if (rvalid) begin
                    nxt <= rdata[ADDR_W-1:0]; cnt <= '0; st <= S_XFER;
                end
                S_XFER: begin
                    if (IS_RX && gnt) begin
                        cnt    <= cnt_nx[FLD_W-1:0];
                        last_q <= s_beat_i.last;
                        if (s_beat_i.last || limit) st <= S_WB;
                    end
                    if (!IS_RX && rvalid) begin word <= rdata; st <= S_MOVE; end
                end
                S_MOVE: if (s_ready_i) begin
                    if (limit) st <= S_WB;
                    else begin cnt <= cnt_nx[FLD_W-1:0]; st <= S_XFER; end
                end
                S_WB: if (gnt || !req) begin
                    if (IS_RX && last_q) begin
                        eof_irq <= 1'b1; st <= S_IDLE;
                    end else if (nxt == '0) st <= S_IDLE;
                    else begin ptr <= nxt; st <= S_HDR; end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/desc_copy_dma.sv
module desc_copy_dma
    import dcp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              owner_chk_en,
    input  logic              auto_wb_en,
    input  logic              tx_start,
    input  logic [ADDR_W-1:0] tx_desc_addr,
    input  logic              rx_start,
    input  logic [ADDR_W-1:0] rx_desc_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              tx_busy,
    output logic              rx_busy,
    output logic              tx_err,
    output logic              rx_err,
    output logic              rx_eof_irq
);
    localparam int BEAT_W = $bits(beat_t);

    logic              t_req, t_we, t_gnt, t_rv, r_req, r_we, r_gnt, r_rv;
    logic [ADDR_W-1:0] t_addr, r_addr;
    logic [31:0]       t_wd, r_wd;
    logic              f_in_v, f_in_r, f_out_v, f_out_r;
    beat_t             f_in_b, f_out_b, t_unused_b, r_unused_b;
    logic              t_unused_r, r_unused_v, t_irq;
    logic [BEAT_W-1:0] f_out_raw;

    assign f_out_b    = beat_t'(f_out_raw);
    assign t_unused_b = '0;

    dcp_chan #(.ADDR_W(ADDR_W), .IS_RX(1'b0)) u_tx (
        .clk, .rst, .start(tx_start), .start_addr(tx_desc_addr),
        .chk_en(owner_chk_en), .wb_en(auto_wb_en),
        .req(t_req), .we(t_we), .addr(t_addr), .wdata(t_wd),
        .gnt(t_gnt), .rvalid(t_rv), .rdata(mem_rdata),
        .s_valid_o(f_in_v), .s_beat_o(f_in_b), .s_ready_i(f_in_r),
        .s_valid_i(1'b0), .s_beat_i(t_unused_b), .s_ready_o(t_unused_r),
        .busy(tx_busy), .err(tx_err), .eof_irq(t_irq)
    );

    dcp_fifo #(.W(BEAT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk, .rst, .i_valid(f_in_v), .i_ready(f_in_r), .i_data(f_in_b),
        .o_valid(f_out_v), .o_ready(f_out_r), .o_data(f_out_raw)
    );

    dcp_chan #(.ADDR_W(ADDR_W), .IS_RX(1'b1)) u_rx (
        .clk, .rst, .start(rx_start), .start_addr(rx_desc_addr),
        .chk_en(owner_chk_en), .wb_en(auto_wb_en),
        .req(r_req), .we(r_we), .addr(r_addr), .wdata(r_wd),
        .gnt(r_gnt), .rvalid(r_rv), .rdata(mem_rdata),
        .s_valid_o(r_unused_v), .s_beat_o(r_unused_b), .s_ready_i(1'b0),
        .s_valid_i(f_out_v), .s_beat_i(f_out_b), .s_ready_o(f_out_r),
        .busy(rx_busy), .err(rx_err), .eof_irq(rx_eof_irq)
    );

    dcp_arb #(.ADDR_W(ADDR_W)) u_arb (
        .clk, .rst,
        .a_req(r_req), .a_we(r_we), .a_addr(r_addr), .a_wdata(r_wd),
        .a_gnt(r_gnt), .a_rvalid(r_rv),
        .b_req(t_req), .b_we(t_we), .b_addr(t_addr), .b_wdata(t_wd),
        .b_gnt(t_gnt), .b_rvalid(t_rv),
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_gnt, .mem_rvalid
    );
endmodule

// File: rtl/desc_copy_dma_chk.sv
module desc_copy_dma_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_start,
    input logic              rx_start,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_gnt,
    input logic              tx_busy,
    input logic              rx_busy,
    input logic              tx_err,
    input logic              rx_err,
    input logic              rx_eof_irq
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!mem_req && !tx_busy && !rx_busy && !tx_err && !rx_err && !rx_eof_irq));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_eof_irq && !rx_start) |=> rx_eof_irq);

    // R4
    tx_err_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_err && !tx_start) |=> (tx_err && !tx_busy));

    // R4
    rx_err_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_err && !rx_start) |=> (rx_err && !rx_busy));
endmodule

bind desc_copy_dma desc_copy_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk, .rst, .tx_start, .rx_start, .mem_req, .mem_we, .mem_addr,
    .mem_wdata, .mem_gnt, .tx_busy, .rx_busy, .tx_err, .rx_err, .rx_eof_irq
);

// File: tb/sim_desc_copy_dma.sv
`timescale 1ns/1ps
module sim_desc_copy_dma;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        owner_chk_en = 1'b1, auto_wb_en = 1'b1;
    logic        tx_start = 1'b0, rx_start = 1'b0;
    logic [15:0] tx_desc_addr = '0, rx_desc_addr = '0;
    logic        mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic        tx_busy, rx_busy, tx_err, rx_err, rx_eof_irq;

    always #4 clk = ~clk;

    desc_copy_dma u0 (.*);

    logic [31:0] mem [0:1023];
    logic [15:0] lfsr = 16'hACE1;
    logic        wr_evt = 1'b0;
    logic [15:0] wr_a;
    logic [31:0] wr_d;
    logic        st_pend = 1'b0;
    logic [15:0] st_addr;
    int          n_chk = 0, n_fail = 0, data_wr = 0, r8_bad = 0;
    logic [15:0] exp_a [$];
    logic [31:0] exp_d [$];

    // memory model with random grant
    always @(negedge clk) begin
        lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_gnt <= lfsr[0] | lfsr[3];
    end
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        wr_evt     <= 1'b0;
        if (!rst) begin
            if (st_pend && (!mem_req || mem_addr != st_addr)) r8_bad <= r8_bad + 1;
            st_pend <= mem_req && !mem_gnt;
            st_addr <= mem_addr;
            if (mem_req && mem_gnt) begin
                if (mem_we) begin
                    mem[mem_addr[11:2]] <= mem_wdata;
                    wr_evt <= 1'b1; wr_a <= mem_addr; wr_d <= mem_wdata;
                end else begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem[mem_addr[11:2]];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: destination writes (addr >= 0x200) popped in order
    always @(negedge clk) begin
        if (wr_evt) begin
            if (wr_a >= 16'h0200) begin
                data_wr++;
                if (exp_a.size() == 0)
                    chk(1'b0, "R3", "unexpected data write", {16'h0, wr_a}, 32'h0);
                else begin
                    logic [15:0] ea;
                    logic [31:0] ed;
                    ea = exp_a.pop_front();
                    ed = exp_d.pop_front();
                    chk(wr_a == ea, "R3", "dest address", {16'h0, wr_a}, {16'h0, ea});
                    chk(wr_d == ed, "R3", "dest data", wr_d, ed);
                end
            end else if (wr_a >= 16'h0040 && wr_a < 16'h0100)
                chk(1'b0, "R3", "write into source area", {16'h0, wr_a}, 32'h0);
        end
    end

    function automatic logic [31:0] pat(input logic [7:0] seed, input int k);
        logic [31:0] w;
        for (int b = 0; b < 4; b++) w[8*b +: 8] = seed + 8'(4*k + b);
        return w;
    endfunction

    task automatic put_desc(input logic [15:0] a, input bit own, input bit eof,
                            input int len, input int size, input logic [15:0] bufp,
                            input logic [15:0] nxt);
        mem[a[11:2]]     = {own, eof, 6'b0, 12'(len), 12'(size)};
        mem[a[11:2] + 1] = {16'h0, bufp};
        mem[a[11:2] + 2] = {16'h0, nxt};
    endtask

    task automatic fill_src(input logic [15:0] base, input int nw, input logic [7:0] seed);
        for (int k = 0; k < nw; k++) mem[base[11:2] + 10'(k)] = pat(seed, k);
    endtask

    task automatic expect_dst(input logic [15:0] base, input int nw, input logic [7:0] seed);
        for (int k = 0; k < nw; k++) begin
            exp_a.push_back(base + 16'(4*k));
            exp_d.push_back(pat(seed, k));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        exp_a.delete(); exp_d.delete(); data_wr = 0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic go(input bit chk_on, input bit wb_on, output bit done);
        owner_chk_en = chk_on; auto_wb_en = wb_on;
        rx_desc_addr = 16'h0100; rx_start = 1'b1;
        @(negedge clk) rx_start = 1'b0;
        tx_desc_addr = 16'h0000; tx_start = 1'b1;
        @(negedge clk) tx_start = 1'b0;
        done = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (rx_eof_irq && !tx_busy && !rx_busy) begin done = 1'b1; break; end
            if (tx_err || rx_err) break;
        end
    endtask

    function automatic logic [31:0] ctl(input logic [15:0] a);
        return mem[a[11:2]];
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        bit done;
        // reset state (R1)
        repeat (2) @(negedge clk);
        chk(!mem_req && !tx_busy && !rx_busy, "R1", "idle in reset", {29'b0, mem_req, tx_busy, rx_busy}, 0);
        do_reset();
        chk(!mem_req && !tx_err && !rx_err && !rx_eof_irq, "R1", "quiet after reset",
            {28'b0, mem_req, tx_err, rx_err, rx_eof_irq}, 0);

        // two 64-byte TX descriptors into one 128-byte RX buffer (R2 R3 R5 R7)
        put_desc(16'h0000, 1, 0, 64, 64, 16'h0040, 16'h000C);
        put_desc(16'h000C, 1, 1, 64, 64, 16'h0080, 16'h0000);
        put_desc(16'h0100, 1, 0, 0, 128, 16'h0200, 16'h0000);
        fill_src(16'h0040, 32, 8'h00);
        expect_dst(16'h0200, 32, 8'h00);
        go(1, 1, done);
        chk(done, "R2", "chain completed", {31'b0, done}, 1);
        chk(exp_a.size() == 0, "R3", "all words stored", exp_a.size(), 0);
        chk(ctl(16'h0000) == {1'b0, 1'b0, 6'b0, 12'd64, 12'd64}, "R5", "tx desc0 returned", ctl(16'h0000), {8'h00, 12'd64, 12'd64});
        chk(ctl(16'h000C) == {1'b0, 1'b1, 6'b0, 12'd64, 12'd64}, "R5", "tx desc1 returned", ctl(16'h000C), {8'h40, 12'd64, 12'd64});
        chk(ctl(16'h0100) == {1'b0, 1'b1, 6'b0, 12'd128, 12'd128}, "R7", "rx desc eof/len", ctl(16'h0100), {8'h40, 12'd128, 12'd128});
        chk(rx_eof_irq, "R7", "irq raised", {31'b0, rx_eof_irq}, 1);
        repeat (5) @(negedge clk);
        chk(rx_eof_irq, "R7", "irq held", {31'b0, rx_eof_irq}, 1);
        rx_desc_addr = 16'h0100; owner_chk_en = 1'b1; rx_start = 1'b1;
        @(negedge clk) rx_start = 1'b0;
        @(negedge clk);
        chk(!rx_eof_irq, "R7", "irq cleared by start", {31'b0, rx_eof_irq}, 0);

        // one TX descriptor split over two RX descriptors (R6)
        do_reset();
        put_desc(16'h0000, 1, 1, 128, 128, 16'h0040, 16'h0000);
        put_desc(16'h0100, 1, 0, 0, 64, 16'h0200, 16'h010C);
        put_desc(16'h010C, 1, 0, 0, 64, 16'h0240, 16'h0000);
        fill_src(16'h0040, 32, 8'h55);
        expect_dst(16'h0200, 32, 8'h55);
        go(1, 1, done);
        chk(done && exp_a.size() == 0, "R6", "split copy done", exp_a.size(), 0);
        chk(ctl(16'h0100) == {1'b0, 1'b0, 6'b0, 12'd64, 12'd64}, "R6", "first rx full, no eof", ctl(16'h0100), {8'h00, 12'd64, 12'd64});
        chk(ctl(16'h010C) == {1'b0, 1'b1, 6'b0, 12'd64, 12'd64}, "R6", "second rx eof", ctl(16'h010C), {8'h40, 12'd64, 12'd64});

        // short frame: 20 bytes into a 128-byte buffer (R7)
        do_reset();
        put_desc(16'h0000, 1, 1, 20, 64, 16'h0040, 16'h0000);
        put_desc(16'h0100, 1, 0, 0, 128, 16'h0200, 16'h0000);
        fill_src(16'h0040, 16, 8'hA0);
        expect_dst(16'h0200, 5, 8'hA0);
        go(1, 1, done);
        chk(done && data_wr == 5, "R7", "short frame word count", data_wr, 5);
        chk(ctl(16'h0100) == {1'b0, 1'b1, 6'b0, 12'd20, 12'd128}, "R7", "rx actual length", ctl(16'h0100), {8'h40, 12'd20, 12'd128});
        chk(mem[16'h0214 >> 2] == 32'h0, "R7", "nothing past length", mem[16'h0214 >> 2], 0);

        // TX descriptor owned by CPU with check on (R4)
        do_reset();
        put_desc(16'h0000, 0, 1, 64, 64, 16'h0040, 16'h0000);
        put_desc(16'h0100, 1, 0, 0, 128, 16'h0200, 16'h0000);
        fill_src(16'h0040, 16, 8'h11);
        go(1, 1, done);
        repeat (20) @(negedge clk);
        chk(tx_err && !tx_busy, "R4", "tx stops with error", {30'b0, tx_err, tx_busy}, 2);
        chk(data_wr == 0 && !rx_eof_irq, "R4", "no data moved", data_wr, 0);
        chk(ctl(16'h0000)[31] == 1'b0, "R4", "refused desc untouched", ctl(16'h0000), {8'h40, 12'd64, 12'd64});

        // RX descriptor owned by CPU with check on (R4)
        do_reset();
        put_desc(16'h0000, 1, 1, 64, 64, 16'h0040, 16'h0000);
        put_desc(16'h0100, 0, 0, 0, 128, 16'h0200, 16'h0000);
        fill_src(16'h0040, 16, 8'h22);
        go(1, 1, done);
        repeat (40) @(negedge clk);
        chk(rx_err && !rx_busy, "R4", "rx stops with error", {30'b0, rx_err, rx_busy}, 2);
        chk(data_wr == 0, "R4", "rx wrote nothing", data_wr, 0);

        // check disabled: CPU-owned descriptors are used anyway (R4)
        do_reset();
        put_desc(16'h0000, 0, 1, 64, 64, 16'h0040, 16'h0000);
        put_desc(16'h0100, 0, 0, 0, 128, 16'h0200, 16'h0000);
        fill_src(16'h0040, 16, 8'h33);
        expect_dst(16'h0200, 16, 8'h33);
        go(0, 1, done);
        chk(done && exp_a.size() == 0 && !tx_err && !rx_err, "R4", "owner ignored", exp_a.size(), 0);

        // write-back off: owner bits stay set (R5)
        do_reset();
        put_desc(16'h0000, 1, 1, 32, 64, 16'h0040, 16'h0000);
        put_desc(16'h0100, 1, 0, 0, 128, 16'h0200, 16'h0000);
        fill_src(16'h0040, 8, 8'h77);
        expect_dst(16'h0200, 8, 8'h77);
        go(1, 0, done);
        chk(done && exp_a.size() == 0, "R5", "copy without write-back", exp_a.size(), 0);
        chk(ctl(16'h0000)[31] == 1'b1, "R5", "tx owner kept", ctl(16'h0000), {8'hC0, 12'd32, 12'd64});
        chk(ctl(16'h0100) == {1'b1, 1'b1, 6'b0, 12'd32, 12'd128}, "R5", "rx owner kept, len set", ctl(16'h0100), {8'hC0, 12'd32, 12'd128});

        chk(r8_bad == 0, "R8", "stalled request held", r8_bad, 0);
        summary();
        $finish;
    end
endmodule